// File: doc/BRIEF.md
# Dual-Bank Keyboard-Controller Host Port

This block is the peripheral half of a keyboard-controller style host port. A host processor reaches it through an 8-bit data bus with an active-low chip select, active-low read and write strobes and two address lines. The low address line picks between the data register and the command/status register. The high address line picks between the keyboard register bank and a second bank of the same shape, kept for power-management traffic. Each bank holds an input register that the host fills, an output register that local firmware fills, and a status byte.

Every host strobe is synchronised into the system clock and acted on at its rising edge, so one access moves a flag exactly once. A local controller port reaches both banks, a configuration byte and a pin byte. While the second bank is disabled, the high address line is ignored and the port behaves as a single-bank interface. An optional hardware fast path lets the host switch the gate-A20 line with a command/data pair that local firmware never sees. Besides the buffer-full interrupt, the block drives a gate-A20 line, an active-low host reset line and two auxiliary buffer-full flags that firmware can enable.

Top module: `hostport_dual_bank`

## Requirements
- R1: After reset, irq_obf and both aux_obf bits are 0, gate_a20 and host_rst_n are 1, and the status byte of each bank reads 0x00.
- R2: A host write sets the input-buffer-full flag (status bit 1) of the selected bank and loads the input register. Status bit 3 takes the value of host_a0 used for that write. Neither changes before the write strobe rises.
- R3: A local read of local address 0 (bank 0) or 2 (bank 1) returns the input register and clears that bank's status bit 1.
- R4: A local write to local address 0 or 2 loads the output register and sets status bit 0 (output buffer full). irq_obf follows bank 0 bit 0. A host data read (host_a0=0) returns the output register and clears bit 0 when the read strobe rises.
- R5: A host read with host_a0=1 returns the status byte of the selected bank and leaves bit 0 set. A local write to local address 1 or 3 sets status bits 2 and 7:4 from the written byte and leaves bits 0, 1 and 3 unchanged.
- R6: With configuration bit 0 (local address 4) set, host_a1=1 reaches bank 1 and bank 0 is left untouched. irq_obf follows bank 0 only.
- R7: With configuration bit 0 clear, host_a1 is ignored and every host access reaches bank 0.
- R8: With configuration bit 1 set, a host command write of A20_CMD (default 0xD1) to bank 0, followed by a host data write, sets gate_a20 to data bit 1. Neither write sets input buffer full. With bit 1 clear, the same command goes to the input register as usual.
- R9: Local address 5 holds the pins: bit 0 drives gate_a20 and bit 1 drives host_rst_n. It reads back the current pin levels.
- R10: With configuration bit 2 set, aux_obf[0] is high while bank 0 has output buffer full and status bit 5 set. With configuration bit 3 set, aux_obf[1] is high while bank 1 has output buffer full.
- R11: A write strobe held low for many clock cycles sets input buffer full exactly once. A flag cleared after that write stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address: 0 selects data, 1 selects command/status |
| host_a1 | input | 1 | Host address: bank select |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | High while a host read is active (drives the pad enable) |
| irq_obf | output | 1 | Output-buffer-full interrupt to the host, active high |
| aux_obf | output | 2 | Auxiliary buffer-full flags |
| gate_a20 | output | 1 | Gate-A20 control line |
| host_rst_n | output | 1 | Host reset, active low |
| loc_we | input | 1 | Local write strobe, one cycle |
| loc_re | input | 1 | Local read strobe, one cycle |
| loc_addr | input | 3 | Local register address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data, valid the cycle after loc_re |

## Verification
The bench builds the block with its defaults: two synchroniser stages and A20_CMD at 0xD1. This keeps strobe-to-flag latency at a few cycles, so every host task can hold its strobes long enough for the edge to land and be seen before the next access starts. The fast-path command is the one the scenarios send, which brings both the absorbed command/data pair and the same pair passing through with the fast path disabled within reach. The bench also holds a write strobe for twenty cycles to show that a flag sets once and only at the rising edge.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int HP_DW     = 8;
  localparam int HP_BANKS  = 2;
  localparam int LOC_AW    = 3;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;
  localparam int ST_AUX = 5;

  typedef enum logic [LOC_AW-1:0] {
    LA_B0_DATA = 3'd0,
    LA_B0_STAT = 3'd1,
    LA_B1_DATA = 3'd2,
    LA_B1_STAT = 3'd3,
    LA_CFG     = 3'd4,
    LA_PINS    = 3'd5
  } loc_addr_e;

  localparam int CFG_B1_EN  = 0;
  localparam int CFG_FAST   = 1;
  localparam int CFG_AUX0   = 2;
  localparam int CFG_AUX1   = 3;
  localparam int CFG_W      = 4;
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hpb_bank.sv
module hpb_bank
  import hpb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_a0,
  input  logic [HP_DW-1:0] host_wdata,
  input  logic             host_rd_done,
  input  logic             loc_rd_in,
  input  logic             loc_wr_out,
  input  logic             loc_wr_stat,
  input  logic [HP_DW-1:0] loc_wdata,
  output logic [HP_DW-1:0] in_q,
  output logic [HP_DW-1:0] out_q,
  output logic [HP_DW-1:0] status
);
  logic       obf, ibf, cmd, user2;
  logic [3:0] user_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0; out_q <= '0;
      obf <= 1'b0; ibf <= 1'b0; cmd <= 1'b0;
      user2 <= 1'b0; user_hi <= '0;
    end else begin
      if (host_wr) begin
        in_q <= host_wdata;
        cmd  <= host_a0;
        ibf  <= 1'b1;
      end else if (loc_rd_in) begin
        ibf  <= 1'b0;
      end
      if (loc_wr_out) begin
        out_q <= loc_wdata;
        obf   <= 1'b1;
      end else if (host_rd_done) begin
        obf   <= 1'b0;
      end
      if (loc_wr_stat) begin
        user2   <= loc_wdata[2];
        user_hi <= loc_wdata[7:4];
      end
    end
  end

  assign status = {user_hi, cmd, user2, ibf, obf};
endmodule

// File: rtl/hpb_a20_fast.sv
module hpb_a20_fast
  import hpb_pkg::*;
#(
  parameter logic [HP_DW-1:0] A20_CMD = 8'hD1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             host_wr,
  input  logic             host_a0,
  input  logic [HP_DW-1:0] host_wdata,
  output logic             absorb,
  output logic             set_a20,
  output logic             set_val
);
  logic armed;
  logic hit, is_cmd;

  assign hit     = host_wr & en;
  assign is_cmd  = host_a0 & (host_wdata == A20_CMD);
  assign set_a20 = hit & ~host_a0 & armed;
  assign absorb  = (hit & is_cmd) | set_a20;
  assign set_val = host_wdata[1];

  always_ff @(posedge clk) begin
    if (rst || !en) armed <= 1'b0;
    else if (hit)   armed <= is_cmd;
  end
endmodule

// File: rtl/hostport_dual_bank.sv
module hostport_dual_bank
  import hpb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [HP_DW-1:0] A20_CMD = 8'hD1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_a0,
  input  logic              host_a1,
  input  logic [HP_DW-1:0]  host_din,
  output logic [HP_DW-1:0]  host_dout,
  output logic              host_doe,
  output logic              irq_obf,
  output logic [1:0]        aux_obf,
  output logic              gate_a20,
  output logic              host_rst_n,
  input  logic              loc_we,
  input  logic              loc_re,
  input  logic [LOC_AW-1:0] loc_addr,
  input  logic [HP_DW-1:0]  loc_wdata,
  output logic [HP_DW-1:0]  loc_rdata
);
  localparam int DATA_SYNC_W = HP_DW + 2;

  // synchronised host pins
  logic cs_s, rd_s, wr_s, a0_s, a1_s;
  logic [HP_DW-1:0] din_s;

  hpb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strb_sync (
    .clk(clk), .rst(rst),
    .d({host_cs_n, host_rd_n, host_wr_n}),
    .q({cs_s, rd_s, wr_s})
  );

  hpb_sync #(.W(DATA_SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst(rst),
    .d({host_a1, host_a0, host_din}),
    .q({a1_s, a0_s, din_s})
  );

  // strobe edge detection with values captured while the strobe is low
  logic wr_prev, rd_prev;
  logic wr_sel_l, wr_a0_l, wr_a1_l, rd_sel_l, rd_a0_l, rd_a1_l;
  logic [HP_DW-1:0] wr_d_l;
  logic wr_pulse, rd_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b1; rd_prev <= 1'b1;
      wr_sel_l <= 1'b0; wr_a0_l <= 1'b0; wr_a1_l <= 1'b0; wr_d_l <= '0;
      rd_sel_l <= 1'b0; rd_a0_l <= 1'b0; rd_a1_l <= 1'b0;
    end else begin
      wr_prev <= wr_s;
      rd_prev <= rd_s;
      if (!wr_s) begin
        wr_sel_l <= ~cs_s; wr_a0_l <= a0_s; wr_a1_l <= a1_s; wr_d_l <= din_s;
      end
      if (!rd_s) begin
        rd_sel_l <= ~cs_s; rd_a0_l <= a0_s; rd_a1_l <= a1_s;
      end
    end
  end

  assign wr_pulse = wr_s & ~wr_prev & wr_sel_l;
  assign rd_done  = rd_s & ~rd_prev & rd_sel_l;

  // configuration
  logic [CFG_W-1:0] cfg_q;
  logic wr_bank, rd_bank, live_bank;

  assign wr_bank   = wr_a1_l & cfg_q[CFG_B1_EN];
  assign rd_bank   = rd_a1_l & cfg_q[CFG_B1_EN];
  assign live_bank = a1_s    & cfg_q[CFG_B1_EN];

  // gate-A20 fast path on bank 0
  logic absorb, fast_set, fast_val;

  hpb_a20_fast #(.A20_CMD(A20_CMD)) u_a20 (
    .clk(clk), .rst(rst),
    .en(cfg_q[CFG_FAST]),
    .host_wr(wr_pulse & ~wr_bank),
    .host_a0(wr_a0_l),
    .host_wdata(wr_d_l),
    .absorb(absorb),
    .set_a20(fast_set),
    .set_val(fast_val)
  );

  // register banks
  logic [HP_DW-1:0] in_q [HP_BANKS];
  logic [HP_DW-1:0] out_q [HP_BANKS];
  logic [HP_DW-1:0] st_q [HP_BANKS];

  for (genvar b = 0; b < HP_BANKS; b++) begin : g_bank
    localparam logic [LOC_AW-1:0] DATA_A = LOC_AW'(2*b);
    localparam logic [LOC_AW-1:0] STAT_A = LOC_AW'(2*b + 1);
    logic sel_w, sel_r;
    assign sel_w = (wr_bank == b[0]);
    assign sel_r = (rd_bank == b[0]);

    hpb_bank u_bank (
      .clk(clk), .rst(rst),
      .host_wr(wr_pulse & sel_w & ~(absorb & (b == 0))),
      .host_a0(wr_a0_l),
      .host_wdata(wr_d_l),
      .host_rd_done(rd_done & ~rd_a0_l & sel_r),
      .loc_rd_in(loc_re & (loc_addr == DATA_A)),
      .loc_wr_out(loc_we & (loc_addr == DATA_A)),
      .loc_wr_stat(loc_we & (loc_addr == STAT_A)),
      .loc_wdata(loc_wdata),
      .in_q(in_q[b]),
      .out_q(out_q[b]),
      .status(st_q[b])
    );
  end

  logic ibf0;
  assign ibf0 = st_q[0][ST_IBF];

  // local registers, pins and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      gate_a20   <= 1'b1;
      host_rst_n <= 1'b1;
      loc_rdata  <= '0;
      host_dout  <= '0;
      host_doe   <= 1'b0;
      irq_obf    <= 1'b0;
      aux_obf    <= '0;
    end else begin
      if (fast_set) gate_a20 <= fast_val;
      if (loc_we) begin
        case (loc_addr)
          LA_CFG:  cfg_q <= loc_wdata[CFG_W-1:0];
          LA_PINS: begin
            gate_a20   <= loc_wdata[0];
            host_rst_n <= loc_wdata[1];
          end
          default: ;
        endcase
      end
      if (loc_re) begin
        case (loc_addr)
          LA_B0_DATA: loc_rdata <= in_q[0];
          LA_B0_STAT: loc_rdata <= st_q[0];
          LA_B1_DATA: loc_rdata <= in_q[1];
          LA_B1_STAT: loc_rdata <= st_q[1];
          LA_CFG:     loc_rdata <= HP_DW'(cfg_q);
          LA_PINS:    loc_rdata <= {6'b0, host_rst_n, gate_a20};
          default:    loc_rdata <= '0;
        endcase
      end
      host_dout  <= a0_s ? st_q[live_bank] : out_q[live_bank];
      host_doe   <= ~cs_s & ~rd_s;
      irq_obf    <= st_q[0][ST_OBF];
      aux_obf[0] <= cfg_q[CFG_AUX0] & st_q[0][ST_OBF] & st_q[0][ST_AUX];
      aux_obf[1] <= cfg_q[CFG_AUX1] & st_q[1][ST_OBF];
    end
  end
endmodule

// File: rtl/hpb_checker.sv
module hpb_checker
  import hpb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              loc_we,
  input logic [LOC_AW-1:0] loc_addr,
  input logic              irq_obf,
  input logic              gate_a20,
  input logic              host_rst_n,
  input logic              ibf0,
  input logic              wr_pulse,
  input logic              fast_set
);
  p_rst_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_obf && gate_a20 && host_rst_n));

  p_ibf_src_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf0) |-> $past(wr_pulse));

  p_irq_src_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_obf) |-> $past(loc_we && loc_addr == 3'd0, 2));

  p_a20_src_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate_a20) |-> $past(fast_set || (loc_we && loc_addr == 3'd5)));

  p_one_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);
endmodule

bind hostport_dual_bank hpb_checker u_chk (
  .clk(clk), .rst(rst), .loc_we(loc_we), .loc_addr(loc_addr),
  .irq_obf(irq_obf), .gate_a20(gate_a20), .host_rst_n(host_rst_n),
  .ibf0(ibf0), .wr_pulse(wr_pulse), .fast_set(fast_set)
);

// File: tb/hostport_dual_bank_tb.sv
module hostport_dual_bank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, a1 = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic doe, irq, gate, hrst_n;
  logic [1:0] aux;
  logic lwe = 1'b0, lre = 1'b0;
  logic [2:0] laddr = '0;
  logic [7:0] lwdata = '0, lrdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hostport_dual_bank u_dut (
    .clk(clk), .rst(rst),
    .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_a0(a0), .host_a1(a1), .host_din(din),
    .host_dout(dout), .host_doe(doe), .irq_obf(irq), .aux_obf(aux),
    .gate_a20(gate), .host_rst_n(hrst_n),
    .loc_we(lwe), .loc_re(lre), .loc_addr(laddr),
    .loc_wdata(lwdata), .loc_rdata(lrdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic b, input logic c, input logic [7:0] d, input int hold);
    @(negedge clk);
    cs_n = 1'b0; a1 = b; a0 = c; din = d;
    waitn(2);
    wr_n = 1'b0;
    waitn(hold);
    wr_n = 1'b1;
    waitn(3);
    cs_n = 1'b1;
    waitn(4);
  endtask

  task automatic host_rd(input logic b, input logic c, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; a1 = b; a0 = c;
    waitn(2);
    rd_n = 1'b0;
    waitn(6);
    d = dout;
    rd_n = 1'b1;
    waitn(3);
    cs_n = 1'b1;
    waitn(4);
  endtask

  task automatic loc_wr(input logic [2:0] ad, input logic [7:0] d);
    @(negedge clk);
    lwe = 1'b1; laddr = ad; lwdata = d;
    @(negedge clk);
    lwe = 1'b0;
  endtask

  task automatic loc_rd(input logic [2:0] ad, output logic [7:0] d);
    @(negedge clk);
    lre = 1'b1; laddr = ad;
    @(negedge clk);
    lre = 1'b0;
    d = lrdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 irq_obf", {7'b0, irq}, 8'h00);
    chk("R1 aux_obf", {6'b0, aux}, 8'h00);
    chk("R1 gate_a20", {7'b0, gate}, 8'h01);
    chk("R1 host_rst_n", {7'b0, hrst_n}, 8'h01);
    loc_rd(3'd1, v); chk("R1 status bank0", v, 8'h00);
    loc_rd(3'd3, v); chk("R1 status bank1", v, 8'h00);
  endtask

  task automatic t_host_write;
    logic [7:0] v;
    host_wr(1'b0, 1'b0, 8'h5A, 3);
    loc_rd(3'd1, v); chk("R2 data write status", v, 8'h02);
    host_wr(1'b0, 1'b1, 8'h20, 3);
    loc_rd(3'd1, v); chk("R2 command write status", v, 8'h0A);
    loc_rd(3'd0, v); chk("R3 input register", v, 8'h20);
    loc_rd(3'd1, v); chk("R3 ibf cleared", v, 8'h08);
  endtask

  task automatic t_output;
    logic [7:0] v;
    loc_wr(3'd0, 8'h3C);
    waitn(2);
    chk("R4 irq_obf set", {7'b0, irq}, 8'h01);
    host_rd(1'b0, 1'b1, v); chk("R5 host status read", v, 8'h09);
    chk("R5 status read keeps irq", {7'b0, irq}, 8'h01);
    host_rd(1'b0, 1'b0, v); chk("R4 host data read", v, 8'h3C);
    chk("R4 irq_obf cleared", {7'b0, irq}, 8'h00);
    loc_rd(3'd1, v); chk("R4 obf cleared", v, 8'h08);
  endtask

  task automatic t_local_bits;
    logic [7:0] v;
    loc_wr(3'd1, 8'hFF);
    host_rd(1'b0, 1'b1, v); chk("R5 local status bits", v, 8'hFC);
    loc_wr(3'd4, 8'h04);
    loc_wr(3'd0, 8'h11);
    waitn(2);
    chk("R10 aux0 with marker", {6'b0, aux}, 8'h01);
    host_rd(1'b0, 1'b0, v); chk("R10 aux data read", v, 8'h11);
    chk("R10 aux0 cleared", {6'b0, aux}, 8'h00);
    loc_wr(3'd1, 8'h00);
    loc_rd(3'd1, v); chk("R5 local bits cleared", v, 8'h08);
  endtask

  task automatic t_bank1;
    logic [7:0] v;
    loc_wr(3'd4, 8'h09);
    host_wr(1'b1, 1'b0, 8'h77, 3);
    loc_rd(3'd3, v); chk("R6 bank1 status", v, 8'h02);
    loc_rd(3'd1, v); chk("R6 bank0 untouched", v, 8'h08);
    loc_rd(3'd2, v); chk("R6 bank1 input", v, 8'h77);
    loc_wr(3'd2, 8'h99);
    waitn(2);
    chk("R10 aux1 set", {6'b0, aux}, 8'h02);
    chk("R6 irq ignores bank1", {7'b0, irq}, 8'h00);
    host_rd(1'b1, 1'b0, v); chk("R6 bank1 host read", v, 8'h99);
    chk("R10 aux1 cleared", {6'b0, aux}, 8'h00);
  endtask

  task automatic t_bank_off;
    logic [7:0] v;
    loc_wr(3'd4, 8'h00);
    host_wr(1'b1, 1'b1, 8'h42, 3);
    loc_rd(3'd1, v); chk("R7 a1 ignored bank0", v, 8'h0A);
    loc_rd(3'd3, v); chk("R7 bank1 untouched", v, 8'h00);
    loc_rd(3'd0, v); chk("R7 input in bank0", v, 8'h42);
  endtask

  task automatic t_a20;
    logic [7:0] v;
    loc_wr(3'd4, 8'h02);
    host_wr(1'b0, 1'b1, 8'hD1, 3);
    host_wr(1'b0, 1'b0, 8'h00, 3);
    chk("R8 fast path low", {7'b0, gate}, 8'h00);
    loc_rd(3'd1, v); chk("R8 ibf untouched", v & 8'h02, 8'h00);
    host_wr(1'b0, 1'b1, 8'hD1, 3);
    host_wr(1'b0, 1'b0, 8'h02, 3);
    chk("R8 fast path high", {7'b0, gate}, 8'h01);
    loc_wr(3'd4, 8'h00);
    host_wr(1'b0, 1'b1, 8'hD1, 3);
    loc_rd(3'd1, v); chk("R8 disabled sets ibf", v & 8'h02, 8'h02);
    loc_rd(3'd0, v); chk("R8 disabled command seen", v, 8'hD1);
    chk("R8 disabled keeps gate", {7'b0, gate}, 8'h01);
  endtask

  task automatic t_pins;
    logic [7:0] v;
    loc_wr(3'd5, 8'h00);
    waitn(1);
    chk("R9 gate low", {7'b0, gate}, 8'h00);
    chk("R9 host reset asserted", {7'b0, hrst_n}, 8'h00);
    loc_rd(3'd5, v); chk("R9 pin readback", v, 8'h00);
    loc_wr(3'd5, 8'h03);
    loc_rd(3'd5, v); chk("R9 pins restored", v, 8'h03);
  endtask

  task automatic t_long_strobe;
    logic [7:0] v;
    @(negedge clk);
    cs_n = 1'b0; a1 = 1'b0; a0 = 1'b0; din = 8'hE7;
    waitn(2);
    wr_n = 1'b0;
    waitn(10);
    loc_rd(3'd1, v); chk("R11 no set while strobe low", v & 8'h02, 8'h00);
    waitn(10);
    wr_n = 1'b1;
    waitn(3);
    cs_n = 1'b1;
    waitn(4);
    loc_rd(3'd1, v); chk("R11 set after rise", v & 8'h02, 8'h02);
    loc_rd(3'd0, v); chk("R11 data", v, 8'hE7);
    waitn(10);
    loc_rd(3'd1, v); chk("R11 stays clear", v & 8'h02, 8'h00);
  endtask

  initial begin
    waitn(4);
    rst = 1'b0;
    waitn(2);
    t_reset;
    t_host_write;
    t_output;
    t_local_bits;
    t_bank1;
    t_bank_off;
    t_a20;
    t_pins;
    t_long_strobe;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule